// File: doc/BRIEF.md
# CAN Command Identifier Decoder

This block sorts the frames a CAN receiver hands over to one node. Each frame arrives as a one-cycle strobe carrying a 29-bit identifier, a 4-bit length code and eight data bytes. The block subtracts the node's current identifier from the frame identifier. The resulting offset, together with the length, selects one command out of a fixed table. Per-channel commands take the channel number from the low nibble of the offset. One cycle after the strobe, an accepted frame produces a command strobe. That strobe carries the command code, the channel, the raw payload and the descriptor of the reply to send back: the reply identifier, the reply byte count and a transaction-report byte. A frame that fits nothing produces a reject pulse instead.

The node identifier resets to a parameter value. The only way to change it is the change-identifier command, and that command is accepted only when the frame carries a 32-bit key. A separate broadcast identifier is always accepted with zero length. It is answered under the node's own identifier, so a host can discover which nodes are present.

Top module: `can_cmd_decoder`

## Requirements
- R1: An offset (identifier minus node identifier, modulo 2^29) outside 0x100..0x1FF gives no command and a reject pulse, unless the frame is the broadcast frame of R7.
- R2: Offsets 0x100+i, 0x110+i, 0x120+i, 0x1C0+i and 0x1E0+i (i = 0..15) decode to command codes 1 (read input), 2 (write output), 3 (read output), 7 (read input correction) and 9 (read output correction), with cmd_chan = i.
- R3: A frame is accepted only when its length code equals the one tied to its offset: 0 for read commands, 2 for write output, 1 for 0x190 and 0x1FF, 4 for 0x1A0, 0x1B0 and 0x1D0, and 8 for 0x1FD and 0x1FE.
- R4: The single-offset commands are decoded as follows: 0x190 to code 4, 0x1A0 to code 5, 0x1B0 to code 6, 0x1D0 to code 8, 0x1FD to code 10, 0x1FE to code 11 and 0x1FF to code 12, all with cmd_chan = 0. Any other offset in the window, such as 0x130 or 0x191, is rejected.
- R5: A control command (codes 2, 4, 5, 6, 8, 10, 11, 12) gives rsp_len = 0 and rsp_id equal to the received identifier.
- R6: A monitor command gives rsp_id equal to the received identifier. Codes 1 and 3 give rsp_len = 3, and codes 7 and 9 give rsp_len = 7.
- R7: A frame whose identifier equals BCAST_ID with length 0 is accepted as code 0. It gives rsp_id equal to the current node identifier and rsp_len = 0.
- R8: The write-output value is byte 0 (frm_data[63:56], the upper half) joined to byte 1. A value above 0x3FFF rejects the frame.
- R9: For monitor commands rsp_rpt carries link_err in bit 2 and zeros elsewhere. For every other command it is 0x00.
- R10: A length-8 frame at offset 0x1FE whose bytes 0..3 equal NODE_KEY sets the node identifier to the low 29 bits of bytes 4..7, starting with the next frame. If the key does not match, the frame is rejected and the node identifier is unchanged.
- R11: cmd_valid and rej_pulse are one-cycle pulses that appear exactly one cycle after a frm_valid cycle, and never both at once. Without frm_valid, neither appears.
- R12: After reset cmd_valid and rej_pulse are low and the node identifier equals NODE_RST.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frm_valid | input | 1 | Received-frame strobe |
| frm_id | input | 29 | Received identifier |
| frm_dlc | input | 4 | Received length code |
| frm_data | input | 64 | Data bytes, byte 0 in bits 63:56 |
| link_err | input | 1 | CAN error state for the report byte |
| cmd_valid | output | 1 | Accepted-command strobe |
| cmd_kind | output | 4 | Command code |
| cmd_chan | output | 4 | Channel number |
| cmd_payload | output | 64 | Frame data of the accepted command |
| rsp_id | output | 29 | Reply identifier |
| rsp_len | output | 4 | Reply data byte count |
| rsp_rpt | output | 8 | Transaction-report byte for the reply |
| rej_pulse | output | 1 | Frame rejected |

## Verification
The assertions assume that frm_valid is a single-cycle strobe and that the identifier, length and data inputs are stable in the strobe cycle. They also assume the length code never exceeds 8. The bench drives every frame in one low-clock window and returns frm_valid to zero before the next edge. It uses only lengths from 0 to 8, so these assumptions always hold. The key-protected identifier change is followed by frames addressed to both the old and the new identifier, which shows from the ports when the change takes effect.

// File: rtl/can_dec_pkg.sv
package can_dec_pkg;

  typedef enum logic [3:0] {
    K_BCAST        = 4'd0,
    K_GET_IN       = 4'd1,
    K_SET_OUT      = 4'd2,
    K_GET_OUT      = 4'd3,
    K_CORR_OFF     = 4'd4,
    K_CAL_IN_OFS   = 4'd5,
    K_CAL_IN_GAIN  = 4'd6,
    K_RD_IN_CORR   = 4'd7,
    K_CAL_OUT      = 4'd8,
    K_RD_OUT_CORR  = 4'd9,
    K_SET_SERIAL   = 4'd10,
    K_SET_NODE     = 4'd11,
    K_RESTART      = 4'd12
  } cmd_kind_e;

  typedef struct packed {
    logic      hit;
    cmd_kind_e kind;
    logic [3:0] want_dlc;
    logic [3:0] reply_len;
    logic      is_mon;
    logic [3:0] chan;
  } cmd_entry_t;

  localparam logic [3:0] MON_SHORT_LEN = 4'd3;
  localparam logic [3:0] MON_LONG_LEN  = 4'd7;

endpackage

// File: rtl/can_offset_calc.sv
module can_offset_calc #(
  parameter int ID_W  = 29,
  parameter int LOW_W = 8
) (
  input  logic [ID_W-1:0]  frame_id,
  input  logic [ID_W-1:0]  node_id,
  output logic             in_window,
  output logic [LOW_W-1:0] off_low
);
  localparam int HI_W = ID_W - LOW_W;

  logic [ID_W-1:0] diff;

  always_comb begin
    diff      = frame_id - node_id;
    off_low   = diff[LOW_W-1:0];
    in_window = (diff[ID_W-1:LOW_W] == HI_W'(1));
  end
endmodule

// File: rtl/can_cmd_classify.sv
module can_cmd_classify
  import can_dec_pkg::*;
(
  input  logic [7:0]  off_low,
  output cmd_entry_t  entry
);
  logic [3:0] grp;
  logic [3:0] sub;

  always_comb begin
    grp = off_low[7:4];
    sub = off_low[3:0];
    entry = '{hit: 1'b0, kind: K_BCAST, want_dlc: 4'd0,
              reply_len: 4'd0, is_mon: 1'b0, chan: 4'd0};
    unique case (grp)
      4'h0: entry = '{1'b1, K_GET_IN,      4'd0, MON_SHORT_LEN, 1'b1, sub};
      4'h1: entry = '{1'b1, K_SET_OUT,     4'd2, 4'd0,          1'b0, sub};
      4'h2: entry = '{1'b1, K_GET_OUT,     4'd0, MON_SHORT_LEN, 1'b1, sub};
      4'hC: entry = '{1'b1, K_RD_IN_CORR,  4'd0, MON_LONG_LEN,  1'b1, sub};
      4'hE: entry = '{1'b1, K_RD_OUT_CORR, 4'd0, MON_LONG_LEN,  1'b1, sub};
      4'h9: if (sub == 4'h0) entry = '{1'b1, K_CORR_OFF,    4'd1, 4'd0, 1'b0, 4'd0};
      4'hA: if (sub == 4'h0) entry = '{1'b1, K_CAL_IN_OFS,  4'd4, 4'd0, 1'b0, 4'd0};
      4'hB: if (sub == 4'h0) entry = '{1'b1, K_CAL_IN_GAIN, 4'd4, 4'd0, 1'b0, 4'd0};
      4'hD: if (sub == 4'h0) entry = '{1'b1, K_CAL_OUT,     4'd4, 4'd0, 1'b0, 4'd0};
      4'hF: begin
        if (sub == 4'hD) entry = '{1'b1, K_SET_SERIAL, 4'd8, 4'd0, 1'b0, 4'd0};
        if (sub == 4'hE) entry = '{1'b1, K_SET_NODE,   4'd8, 4'd0, 1'b0, 4'd0};
        if (sub == 4'hF) entry = '{1'b1, K_RESTART,    4'd1, 4'd0, 1'b0, 4'd0};
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/can_node_reg.sv
module can_node_reg #(
  parameter int              ID_W     = 29,
  parameter logic [ID_W-1:0] NODE_RST = '0
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic [ID_W-1:0] wr_val,
  output logic [ID_W-1:0] node_id
);
  logic [ID_W-1:0] node_d;

  always_comb begin
    node_d = node_id;
    if (wr_en) node_d = wr_val;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) node_id <= NODE_RST;
    else        node_id <= node_d;
  end

  a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(wr_en) |-> $stable(node_id));
endmodule

// File: rtl/can_cmd_decoder.sv
module can_cmd_decoder
  import can_dec_pkg::*;
#(
  parameter int           ID_W          = 29,
  parameter int           DLC_W         = 4,
  parameter int           NBYTES        = 8,
  parameter logic [28:0]  NODE_RST      = 29'h40,
  parameter logic [28:0]  BCAST_ID      = 29'h0,
  parameter logic [31:0]  NODE_KEY      = 32'hA5C3_1E7F,
  parameter logic [3:0]   BCAST_RSP_LEN = 4'd0
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  frm_valid,
  input  logic [ID_W-1:0]       frm_id,
  input  logic [DLC_W-1:0]      frm_dlc,
  input  logic [NBYTES*8-1:0]   frm_data,
  input  logic                  link_err,
  output logic                  cmd_valid,
  output logic [3:0]            cmd_kind,
  output logic [3:0]            cmd_chan,
  output logic [NBYTES*8-1:0]   cmd_payload,
  output logic [ID_W-1:0]       rsp_id,
  output logic [3:0]            rsp_len,
  output logic [7:0]            rsp_rpt,
  output logic                  rej_pulse
);
  localparam int DATA_W  = NBYTES * 8;
  localparam int ERR_BIT = 2;
  localparam int KEY_W   = 32;

  logic [ID_W-1:0] node_id;
  logic            in_window;
  logic [7:0]      off_low;
  cmd_entry_t      entry;

  logic            is_bcast, dlc_ok, val_ok, key_ok, cmd_ok, accept, node_wr;
  logic [15:0]     out_val;

  logic                cmd_valid_d, rej_d;
  logic [3:0]          kind_d, chan_d, len_d;
  logic [ID_W-1:0]     rid_d;
  logic [7:0]          rpt_d;

  can_offset_calc #(.ID_W(ID_W), .LOW_W(8)) u_off (
    .frame_id (frm_id),
    .node_id  (node_id),
    .in_window(in_window),
    .off_low  (off_low)
  );

  can_cmd_classify u_cls (
    .off_low(off_low),
    .entry  (entry)
  );

  can_node_reg #(.ID_W(ID_W), .NODE_RST(NODE_RST)) u_node (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (node_wr),
    .wr_val (frm_data[ID_W-1:0]),
    .node_id(node_id)
  );

  always_comb begin
    out_val  = frm_data[DATA_W-1 -: 16];
    is_bcast = (frm_id == BCAST_ID) && (frm_dlc == '0);
    dlc_ok   = (frm_dlc == DLC_W'(entry.want_dlc));
    val_ok   = (entry.kind != K_SET_OUT) || (out_val[15:14] == 2'b00);
    key_ok   = (entry.kind != K_SET_NODE) ||
               (frm_data[DATA_W-1 -: KEY_W] == NODE_KEY);
    cmd_ok   = in_window && entry.hit && dlc_ok && val_ok && key_ok;
    accept   = frm_valid && (is_bcast || cmd_ok);
    node_wr  = frm_valid && !is_bcast && cmd_ok && (entry.kind == K_SET_NODE);

    cmd_valid_d = accept;
    rej_d       = frm_valid && !accept;
    if (is_bcast) begin
      kind_d = 4'(K_BCAST);
      chan_d = 4'd0;
      rid_d  = node_id;
      len_d  = BCAST_RSP_LEN;
      rpt_d  = 8'h00;
    end else begin
      kind_d = 4'(entry.kind);
      chan_d = entry.chan;
      rid_d  = frm_id;
      len_d  = entry.reply_len;
      rpt_d  = 8'h00;
      if (entry.is_mon) rpt_d[ERR_BIT] = link_err;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_valid <= 1'b0;
      rej_pulse <= 1'b0;
    end else begin
      cmd_valid <= cmd_valid_d;
      rej_pulse <= rej_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_kind    <= '0;
      cmd_chan    <= '0;
      cmd_payload <= '0;
      rsp_id      <= '0;
      rsp_len     <= '0;
      rsp_rpt     <= '0;
    end else if (accept) begin
      cmd_kind    <= kind_d;
      cmd_chan    <= chan_d;
      cmd_payload <= frm_data;
      rsp_id      <= rid_d;
      rsp_len     <= len_d;
      rsp_rpt     <= rpt_d;
    end
  end

  a_r11_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(cmd_valid && rej_pulse));

  a_r11_needs_frame: assert property (@(posedge clk) disable iff (!rst_n)
    !frm_valid |=> !(cmd_valid || rej_pulse));

  a_r11_frame_answered: assert property (@(posedge clk) disable iff (!rst_n)
    frm_valid |=> (cmd_valid || rej_pulse));

  a_r5_ctrl_ack: assert property (@(posedge clk) disable iff (!rst_n)
    frm_valid && !is_bcast && accept && !entry.is_mon
      |=> (rsp_len == 4'd0) && (rsp_id == $past(frm_id)));

  a_r6_mon_len: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && (cmd_kind == 4'(K_GET_IN) || cmd_kind == 4'(K_GET_OUT))
      |-> rsp_len == MON_SHORT_LEN);

  a_r8_bound: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && (cmd_kind == 4'(K_SET_OUT)) |-> cmd_payload[DATA_W-1 -: 2] == 2'b00);

  a_r3_read_len: assert property (@(posedge clk) disable iff (!rst_n)
    frm_valid && !is_bcast && (frm_dlc != '0) && entry.is_mon |=> !cmd_valid);
endmodule

// File: tb/can_cmd_decoder_tb.sv
module can_cmd_decoder_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        frm_valid;
  logic [28:0] frm_id;
  logic [3:0]  frm_dlc;
  logic [63:0] frm_data;
  logic        link_err;
  logic        cmd_valid, rej_pulse;
  logic [3:0]  cmd_kind, cmd_chan, rsp_len;
  logic [63:0] cmd_payload;
  logic [28:0] rsp_id;
  logic [7:0]  rsp_rpt;

  int n_run = 0;
  int n_fail = 0;
  localparam logic [28:0] NODE0 = 29'h40;
  localparam logic [31:0] KEY   = 32'hA5C3_1E7F;

  always #4 clk = ~clk;

  can_cmd_decoder u_dut (
    .clk(clk), .rst_n(rst_n), .frm_valid(frm_valid), .frm_id(frm_id),
    .frm_dlc(frm_dlc), .frm_data(frm_data), .link_err(link_err),
    .cmd_valid(cmd_valid), .cmd_kind(cmd_kind), .cmd_chan(cmd_chan),
    .cmd_payload(cmd_payload), .rsp_id(rsp_id), .rsp_len(rsp_len),
    .rsp_rpt(rsp_rpt), .rej_pulse(rej_pulse)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic send(input logic [28:0] id, input logic [3:0] dlc,
                      input logic [63:0] data, input logic err);
    @(negedge clk);
    frm_valid = 1'b1; frm_id = id; frm_dlc = dlc; frm_data = data; link_err = err;
    @(negedge clk);
    frm_valid = 1'b0;
  endtask

  task automatic expect_cmd(input string tag, input logic [3:0] k, input logic [3:0] ch,
                            input logic [28:0] rid, input logic [3:0] rl, input logic [7:0] rp);
    chk({tag, " valid"}, {rej_pulse, cmd_valid}, 2'b01);
    chk({tag, " kind"}, cmd_kind, k);
    chk({tag, " chan"}, cmd_chan, ch);
    chk({tag, " rsp_id"}, rsp_id, rid);
    chk({tag, " rsp_len"}, rsp_len, rl);
    chk({tag, " rpt"}, rsp_rpt, rp);
  endtask

  task automatic expect_rej(input string tag);
    chk({tag, " reject"}, {rej_pulse, cmd_valid}, 2'b10);
  endtask

  task automatic t_reset;
    chk("R12 reset outputs", {rej_pulse, cmd_valid}, 2'b00);
    send(NODE0 + 29'h100, 4'd0, 64'h0, 1'b0);
    expect_cmd("R12 reset node id", 4'd1, 4'd0, NODE0 + 29'h100, 4'd3, 8'h00);
  endtask

  task automatic t_channels;
    send(NODE0 + 29'h105, 4'd0, 64'h0, 1'b1);
    expect_cmd("R2 R6 R9 get input ch5", 4'd1, 4'd5, NODE0 + 29'h105, 4'd3, 8'h04);
    send(NODE0 + 29'h12F, 4'd0, 64'h0, 1'b0);
    expect_cmd("R2 R6 get output ch15", 4'd3, 4'd15, NODE0 + 29'h12F, 4'd3, 8'h00);
    send(NODE0 + 29'h1C3, 4'd0, 64'h0, 1'b1);
    expect_cmd("R2 R6 in corr ch3", 4'd7, 4'd3, NODE0 + 29'h1C3, 4'd7, 8'h04);
    send(NODE0 + 29'h1EA, 4'd0, 64'h0, 1'b0);
    expect_cmd("R2 R6 out corr ch10", 4'd9, 4'd10, NODE0 + 29'h1EA, 4'd7, 8'h00);
  endtask

  task automatic t_set_out;
    send(NODE0 + 29'h11F, 4'd2, 64'h3FFF_0000_0000_0000, 1'b1);
    expect_cmd("R8 R5 R9 set out max", 4'd2, 4'd15, NODE0 + 29'h11F, 4'd0, 8'h00);
    chk("R8 payload", cmd_payload, 64'h3FFF_0000_0000_0000);
    send(NODE0 + 29'h110, 4'd2, 64'h4000_0000_0000_0000, 1'b0);
    expect_rej("R8 set out over range");
  endtask

  task automatic t_singles;
    send(NODE0 + 29'h190, 4'd1, 64'h0, 1'b1);
    expect_cmd("R4 R5 R9 corr off", 4'd4, 4'd0, NODE0 + 29'h190, 4'd0, 8'h00);
    send(NODE0 + 29'h1A0, 4'd4, 64'h0, 1'b0);
    expect_cmd("R4 cal in ofs", 4'd5, 4'd0, NODE0 + 29'h1A0, 4'd0, 8'h00);
    send(NODE0 + 29'h1B0, 4'd4, 64'h0, 1'b0);
    expect_cmd("R4 cal in gain", 4'd6, 4'd0, NODE0 + 29'h1B0, 4'd0, 8'h00);
    send(NODE0 + 29'h1D0, 4'd4, 64'h0, 1'b0);
    expect_cmd("R4 cal out", 4'd8, 4'd0, NODE0 + 29'h1D0, 4'd0, 8'h00);
    send(NODE0 + 29'h1FD, 4'd8, 64'h1234, 1'b0);
    expect_cmd("R4 serial", 4'd10, 4'd0, NODE0 + 29'h1FD, 4'd0, 8'h00);
    send(NODE0 + 29'h1FF, 4'd1, 64'h0, 1'b0);
    expect_cmd("R4 restart", 4'd12, 4'd0, NODE0 + 29'h1FF, 4'd0, 8'h00);
    send(NODE0 + 29'h130, 4'd0, 64'h0, 1'b0);
    expect_rej("R4 unused group 0x130");
    send(NODE0 + 29'h191, 4'd1, 64'h0, 1'b0);
    expect_rej("R4 offset 0x191");
  endtask

  task automatic t_lengths;
    send(NODE0 + 29'h101, 4'd1, 64'h0, 1'b0);
    expect_rej("R3 read with length 1");
    send(NODE0 + 29'h1A0, 4'd3, 64'h0, 1'b0);
    expect_rej("R3 cal with length 3");
    send(NODE0 + 29'h1FF, 4'd0, 64'h0, 1'b0);
    expect_rej("R3 restart with length 0");
  endtask

  task automatic t_window;
    send(NODE0 + 29'h0FF, 4'd0, 64'h0, 1'b0);
    expect_rej("R1 offset 0x0FF");
    send(NODE0 + 29'h200, 4'd0, 64'h0, 1'b0);
    expect_rej("R1 offset 0x200");
    send(NODE0 - 29'h1, 4'd0, 64'h0, 1'b0);
    expect_rej("R1 negative offset");
  endtask

  task automatic t_bcast;
    send(29'h0, 4'd0, 64'h0, 1'b1);
    expect_cmd("R7 broadcast", 4'd0, 4'd0, NODE0, 4'd0, 8'h00);
    send(29'h0, 4'd1, 64'h0, 1'b0);
    expect_rej("R7 broadcast with data");
  endtask

  task automatic t_idle;
    @(negedge clk);
    @(negedge clk);
    chk("R11 idle no pulse", {rej_pulse, cmd_valid}, 2'b00);
  endtask

  task automatic t_node;
    send(NODE0 + 29'h1FE, 4'd8, {KEY ^ 32'h1, 32'h0000_0200}, 1'b0);
    expect_rej("R10 wrong key");
    send(NODE0 + 29'h102, 4'd0, 64'h0, 1'b0);
    expect_cmd("R10 id kept", 4'd1, 4'd2, NODE0 + 29'h102, 4'd3, 8'h00);
    send(NODE0 + 29'h1FE, 4'd8, {KEY, 32'h0000_0200}, 1'b0);
    expect_cmd("R10 R5 set node", 4'd11, 4'd0, NODE0 + 29'h1FE, 4'd0, 8'h00);
    send(29'h200 + 29'h104, 4'd0, 64'h0, 1'b0);
    expect_cmd("R10 new id used", 4'd1, 4'd4, 29'h304, 4'd3, 8'h00);
    send(NODE0 + 29'h104, 4'd0, 64'h0, 1'b0);
    expect_rej("R10 old id dropped");
    send(29'h0, 4'd0, 64'h0, 1'b0);
    expect_cmd("R7 R10 broadcast new id", 4'd0, 4'd0, 29'h200, 4'd0, 8'h00);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; frm_valid = 1'b0; frm_id = '0; frm_dlc = '0;
    frm_data = '0; link_err = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_channels;
    t_set_out;
    t_singles;
    t_lengths;
    t_window;
    t_bcast;
    t_idle;
    t_node;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule